// File: doc/BRIEF.md
# Counted-burst PWM channel

A single pulse-width channel whose waveform is set by three 16-bit counts: a base period, a rise point and a fall point. A counter steps from zero to one below the base period on every enabled tick; the output is high while the count is at or past the rise point and still below the fall point, and an invert flag flips the whole waveform, idle level included. A base period of 0 or 1 is run as 2.

The channel either runs freely or emits a programmed number of full periods and then stops by itself. Software controls it through a small word-addressed register port: a shape word (low bytes plus invert flag), an extension word (high bytes), a burst-count word, write-one strobes for start, stop and load, an interrupt-enable bit and a write-one-to-clear completion flag. Loads and stop requests are held until the current period ends, so no period is ever cut short. The register port has no flow control: a write is taken in the cycle `wr_en` is high and reads are combinational, so there is no back-pressure anywhere. The `tick` input stands in for a divided clock.

Top module: `pwm_burst_chan`

## Requirements
- R1: After reset the channel is idle (start address 3 reads bit0 = 0), `pwm_o` is 0, `irq_o` is 0 and the completion flag (address 7 bit0) is 0.
- R2: A write of bit0 = 1 to address 3 while idle starts the channel with the count at 0 from the next cycle; the count advances on each cycle with `tick` high and wraps after base period minus 1; `pwm_o` is high when rise <= count < fall; an idle channel drives the inactive level.
- R3: Shape word (address 0) bit 28 inverts `pwm_o` both while running and while idle.
- R4: A base period of 0 or 1 behaves exactly like a base period of 2.
- R5: The shape word carries rise in bits 7:0, fall in bits 15:8 and base period in bits 23:16; the extension word (address 1) carries the upper bytes of the same fields in the same positions, giving 16-bit values.
- R6: With a nonzero burst count N (address 2, bits 15:0) the channel stops after exactly N full periods; running clears and the completion flag sets on the same clock edge.
- R7: A burst count of 0 makes the channel run until stopped.
- R8: Writing bit0 = 1 to address 4 while running lets the current period finish, then stops the channel and sets the completion flag.
- R9: Shape and extension writes do not alter a running waveform; a write of bit0 = 1 to address 5 commits them at the next period boundary.
- R10: `irq_o` is high only while both the completion flag and the enable bit (address 6 bit0) are set; writing 1 to address 7 bit0 clears the flag, writing 0 leaves it.
- R11: While `tick` is low the count, and thus `pwm_o`, hold their value.
- R12: A start while running is ignored, and a stop while idle is ignored and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable standing in for the divided clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data, combinational |
| pwm_o | output | 1 | Waveform output |
| irq_o | output | 1 | Completion interrupt |

## Verification
A write is taken at the edge that follows it, so the count is 0 in the first sample after a start write and each later sample is one count further; the bench predicts each output as a modulo of the samples since start and samples on the falling edge. Burst completion, stop and load all act at the edge that ends a period, so the flag and the idle level appear in the sample directly after the last count of that period, and the bench places each request a known number of samples before that edge. Interrupt and flag reads are combinational and are checked in the sample after the write that changes them.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;
  localparam int unsigned AW      = 3;
  localparam int unsigned DW      = 32;
  localparam int unsigned BW      = 8;
  localparam int unsigned FW      = 2 * BW;
  localparam int unsigned INV_POS = 28;

  localparam logic [AW-1:0] A_SHAPE = 3'd0;
  localparam logic [AW-1:0] A_EXT   = 3'd1;
  localparam logic [AW-1:0] A_COUNT = 3'd2;
  localparam logic [AW-1:0] A_START = 3'd3;
  localparam logic [AW-1:0] A_STOP  = 3'd4;
  localparam logic [AW-1:0] A_LOAD  = 3'd5;
  localparam logic [AW-1:0] A_IEN   = 3'd6;
  localparam logic [AW-1:0] A_STS   = 3'd7;

  typedef struct packed {
    logic [FW-1:0] rise;
    logic [FW-1:0] fall;
    logic [FW-1:0] per;
  } shape_t;
endpackage

// File: rtl/pwm_burst_regs.sv
module pwm_burst_regs
  import pwm_burst_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          running,
  input  logic          done_evt,
  output shape_t        stage,
  output logic [FW-1:0] burst,
  output logic          inv,
  output logic          ien,
  output logic          sts,
  output logic          start_p,
  output logic          stop_p,
  output logic          load_p
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[DW-1:INV_POS+1], wr_data[INV_POS-1:3*BW]};

  function automatic logic hit(input logic [AW-1:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  assign start_p = hit(A_START) && wr_data[0];
  assign stop_p  = hit(A_STOP)  && wr_data[0];
  assign load_p  = hit(A_LOAD)  && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      burst <= '0;
      inv   <= 1'b0;
      ien   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_SHAPE: begin
          stage.rise[BW-1:0] <= wr_data[BW-1:0];
          stage.fall[BW-1:0] <= wr_data[2*BW-1:BW];
          stage.per[BW-1:0]  <= wr_data[3*BW-1:2*BW];
          inv                <= wr_data[INV_POS];
        end
        A_EXT: begin
          stage.rise[FW-1:BW] <= wr_data[BW-1:0];
          stage.fall[FW-1:BW] <= wr_data[2*BW-1:BW];
          stage.per[FW-1:BW]  <= wr_data[3*BW-1:2*BW];
        end
        A_COUNT: burst <= wr_data[FW-1:0];
        A_IEN:   ien   <= wr_data[0];
        default: ;
      endcase
    end
  end

  // completion wins over a clear that lands in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        sts <= 1'b0;
    else if (done_evt)                 sts <= 1'b1;
    else if (hit(A_STS) && wr_data[0]) sts <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_SHAPE: begin
        rd_data[BW-1:0]      = stage.rise[BW-1:0];
        rd_data[2*BW-1:BW]   = stage.fall[BW-1:0];
        rd_data[3*BW-1:2*BW] = stage.per[BW-1:0];
        rd_data[INV_POS]     = inv;
      end
      A_EXT: begin
        rd_data[BW-1:0]      = stage.rise[FW-1:BW];
        rd_data[2*BW-1:BW]   = stage.fall[FW-1:BW];
        rd_data[3*BW-1:2*BW] = stage.per[FW-1:BW];
      end
      A_COUNT: rd_data[FW-1:0] = burst;
      A_START: rd_data[0] = running;
      A_IEN:   rd_data[0] = ien;
      A_STS:   rd_data[0] = sts;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_burst_engine.sv
module pwm_burst_engine
  import pwm_burst_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          load_p,
  input  shape_t        stage,
  input  logic [FW-1:0] burst,
  output logic          running,
  output logic          win,
  output logic          done_evt
);
  localparam logic [FW-1:0] MIN_PER = FW'(2);
  localparam logic [FW-1:0] ONE     = FW'(1);

  shape_t        act;
  logic [FW-1:0] cnt_q, done_q, burst_a, per_eff;
  logic          run_q, stop_pend, load_pend;
  logic          stop_now, load_now, last, burst_end, finish;

  assign per_eff   = (act.per < MIN_PER) ? MIN_PER : act.per;
  assign last      = (cnt_q == per_eff - ONE);
  assign stop_now  = stop_pend | stop_p;
  assign load_now  = load_pend | load_p;
  assign burst_end = (burst_a != '0) && (done_q == burst_a - ONE);
  assign finish    = run_q && tick && last && (stop_now || burst_end);
  assign done_evt  = finish;
  assign running   = run_q;
  assign win       = run_q && (cnt_q >= act.rise) && (cnt_q < act.fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= '0;
      cnt_q     <= '0;
      done_q    <= '0;
      burst_a   <= '0;
      run_q     <= 1'b0;
      stop_pend <= 1'b0;
      load_pend <= 1'b0;
    end else if (!run_q) begin
      if (start_p) begin
        run_q     <= 1'b1;
        act       <= stage;
        burst_a   <= burst;
        cnt_q     <= '0;
        done_q    <= '0;
        stop_pend <= 1'b0;
        load_pend <= 1'b0;
      end
    end else if (tick && last) begin
      cnt_q <= '0;
      if (stop_now || burst_end) begin
        run_q     <= 1'b0;
        stop_pend <= 1'b0;
        load_pend <= 1'b0;
      end else begin
        done_q    <= done_q + ONE;
        stop_pend <= 1'b0;
        load_pend <= 1'b0;
        if (load_now) act <= stage;
      end
    end else begin
      if (tick) cnt_q <= cnt_q + ONE;
      if (stop_p) stop_pend <= 1'b1;
      if (load_p) load_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_burst_chan.sv
module pwm_burst_chan
  import pwm_burst_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          pwm_o,
  output logic          irq_o
);
  shape_t        stage;
  logic [FW-1:0] burst;
  logic          inv, ien, sts;
  logic          start_p, stop_p, load_p;
  logic          running, win, done_evt;

  pwm_burst_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .running(running), .done_evt(done_evt),
    .stage(stage), .burst(burst), .inv(inv), .ien(ien), .sts(sts),
    .start_p(start_p), .stop_p(stop_p), .load_p(load_p)
  );

  pwm_burst_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start_p(start_p), .stop_p(stop_p), .load_p(load_p),
    .stage(stage), .burst(burst),
    .running(running), .win(win), .done_evt(done_evt)
  );

  assign pwm_o = inv ^ win;
  assign irq_o = sts & ien;
endmodule

// File: rtl/pwm_burst_chk.sv
module pwm_burst_chk #(
  parameter int unsigned FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          run,
  input logic [FW-1:0] cnt,
  input logic [FW-1:0] per_eff,
  input logic [FW-1:0] done_cnt,
  input logic [FW-1:0] burst,
  input logic          sts,
  input logic          ien,
  input logic          irq
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < per_eff)); // R2
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0)); // R2
  AST_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (run && $stable(cnt))); // R11
  AST_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> sts); // R6
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && burst != '0) |-> (done_cnt < burst)); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien); // R10
endmodule

bind pwm_burst_chan pwm_burst_chk #(.FW(pwm_burst_pkg::FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .run(u_eng.run_q), .cnt(u_eng.cnt_q), .per_eff(u_eng.per_eff),
  .done_cnt(u_eng.done_q), .burst(u_eng.burst_a),
  .sts(sts), .ien(ien), .irq(irq_o)
);

// File: tb/sim_pwm_burst_chan.sv
module sim_pwm_burst_chan;
  import pwm_burst_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          pwm_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  pwm_burst_chan u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] val);
    rd_addr = a;
    #1;
    val = rd_data;
  endtask

  function automatic logic [31:0] shp(input int r, input int f, input int p, input logic iv);
    return {3'b0, iv, 4'b0, p[7:0], f[7:0], r[7:0]};
  endfunction

  function automatic logic expv(input int k, input int r, input int f, input int eff, input logic iv);
    int c;
    c = k % eff;
    return iv ^ ((c >= r) && (c < f));
  endfunction

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 pwm", pwm_o, 0);
    chk("R1 irq", irq_o, 0);
    rd(A_START, v); chk("R1 running", v, 0);
    rd(A_STS, v);   chk("R1 flag", v, 0);

    // R2 R3 R4 R6 sweep: every rise/fall for periods 0..5, burst of 2
    for (int p = 0; p <= 5; p++) begin
      int eff;
      eff = (p < 2) ? 2 : p;
      for (int r = 0; r <= eff; r++) begin
        for (int f = 0; f <= eff + 1; f++) begin
          logic iv;
          iv = logic'((p + r + f) % 2);
          wr(A_SHAPE, shp(r, f, p, iv));
          chk("R3 idle level", pwm_o, iv);
          wr(A_COUNT, 2);
          wr(A_START, 1);
          for (int k = 0; k < 2 * eff; k++) begin
            if (p < 2) chk("R4 short period", pwm_o, expv(k, r, f, eff, iv));
            else if (iv) chk("R3 inverted wave", pwm_o, expv(k, r, f, eff, iv));
            else chk("R2 wave", pwm_o, expv(k, r, f, eff, iv));
            step();
          end
          rd(A_START, v); chk("R6 stopped after N", v, 0);
          rd(A_STS, v);   chk("R6 flag set", v, 1);
          chk("R2 idle after burst", pwm_o, iv);
          wr(A_STS, 1);
        end
      end
    end

    // R5 extension bytes: period 258, fall 256
    wr(A_SHAPE, shp(0, 0, 2, 1'b0));
    wr(A_EXT, 32'h0001_0100);
    wr(A_COUNT, 1);
    wr(A_START, 1);
    for (int k = 0; k < 258; k++) begin
      chk("R5 wide values", pwm_o, (k < 256) ? 1 : 0);
      step();
    end
    rd(A_START, v); chk("R5 period length", v, 0);
    wr(A_STS, 1);
    wr(A_EXT, 0);

    // R7 free run, then R8 stop at boundary
    wr(A_SHAPE, shp(1, 3, 4, 1'b0));
    wr(A_COUNT, 0);
    wr(A_START, 1);
    for (int k = 0; k < 41; k++) begin
      chk("R7 free run", pwm_o, expv(k, 1, 3, 4, 1'b0));
      step();
    end
    chk("R7 free run", pwm_o, expv(41, 1, 3, 4, 1'b0));
    wr(A_STOP, 1);
    chk("R8 period finishes", pwm_o, 1);
    rd(A_START, v); chk("R8 still running", v, 1);
    step();
    rd(A_START, v); chk("R8 still running last count", v, 1);
    step();
    rd(A_START, v); chk("R8 stopped", v, 0);
    rd(A_STS, v);   chk("R8 flag", v, 1);
    chk("R8 idle", pwm_o, 0);
    wr(A_STS, 1);

    // R9 staged values wait for load and boundary
    wr(A_SHAPE, shp(0, 1, 4, 1'b0));
    wr(A_START, 1);
    chk("R9 old wave", pwm_o, 1);
    step();
    wr(A_SHAPE, shp(0, 3, 4, 1'b0));
    chk("R9 no load yet", pwm_o, 0);
    repeat (3) step();
    chk("R9 staged ignored", pwm_o, 0);
    repeat (4) step();
    chk("R9 staged ignored", pwm_o, 0);
    wr(A_LOAD, 1);
    chk("R9 load waits", pwm_o, 0);
    step(); step();
    chk("R9 new wave", pwm_o, 1);
    step(); chk("R9 new wave", pwm_o, 1);
    step(); chk("R9 new wave", pwm_o, 1);
    step(); chk("R9 new wave", pwm_o, 0);
    wr(A_STOP, 1);
    repeat (4) step();
    rd(A_START, v); chk("R8 stop after load", v, 0);
    wr(A_STS, 1);

    // R12 start while running ignored
    wr(A_SHAPE, shp(0, 2, 4, 1'b0));
    wr(A_COUNT, 1);
    wr(A_START, 1);
    step();
    wr(A_START, 1);
    chk("R12 restart ignored", pwm_o, 0);
    step();
    step();
    rd(A_START, v); chk("R12 burst not extended", v, 0);
    wr(A_STS, 1);
    wr(A_STOP, 1);
    step();
    rd(A_STS, v);   chk("R12 idle stop no flag", v, 0);
    rd(A_START, v); chk("R12 idle stop stays idle", v, 0);

    // R10 interrupt gating and clear
    wr(A_SHAPE, shp(0, 1, 2, 1'b0));
    wr(A_START, 1);
    step(); step();
    rd(A_STS, v); chk("R10 flag", v, 1);
    chk("R10 irq masked", irq_o, 0);
    wr(A_IEN, 1);
    chk("R10 irq enabled", irq_o, 1);
    wr(A_STS, 0);
    chk("R10 zero write keeps", irq_o, 1);
    wr(A_STS, 1);
    chk("R10 cleared", irq_o, 0);
    wr(A_START, 1);
    step(); step();
    chk("R10 irq on completion", irq_o, 1);
    wr(A_STS, 1);
    wr(A_IEN, 0);

    // R11 tick low freezes count
    wr(A_SHAPE, shp(1, 3, 4, 1'b0));
    wr(A_START, 1);
    chk("R11 cnt0", pwm_o, 0);
    step();
    chk("R11 cnt1", pwm_o, 1);
    tick = 1'b0;
    step(); chk("R11 frozen", pwm_o, 1);
    step(); chk("R11 frozen", pwm_o, 1);
    step(); chk("R11 frozen", pwm_o, 1);
    rd(A_START, v); chk("R11 still running", v, 1);
    tick = 1'b1;
    step(); chk("R11 resumes cnt2", pwm_o, 1);
    step(); chk("R11 resumes cnt3", pwm_o, 0);
    step();
    rd(A_START, v); chk("R11 burst ends", v, 0);

    finish_up();
  end
endmodule